// File: doc/BRIEF.md
# Nine-State Sequence Counter

This block is a synchronous 4-bit counter that walks a fixed loop of nine codes that is not binary order. Its four state bits live in J-K storage cells that update on the falling clock edge. A small excitation stage turns the present code and the control inputs into one J and one K per cell. With enable high the counter moves one place around the loop on each falling edge. With enable low it holds. An active-high synchronous reset puts it back to the start code 0011.

Bit A is the most significant bit of the output and bit D the least significant. The seven codes outside the loop cannot be reached from the ports. The excitation still sends every one of them to the start code in one enabled edge, so no code can get stuck. The control for reset and enable also goes through the excitation, so the cells hold no logic of their own beyond the J-K rule.

Top module: `seq9_counter`

## Requirements
- R1: While `rst` is high at a falling clock edge, `count` becomes 4'b0011 after that edge, from any present code.
- R2: Reset has priority: with `rst` and `en` both high, the next code is 4'b0011 and not the successor.
- R3: With `rst` low and `en` low, `count` keeps its value across falling edges.
- R4: With `rst` low and `en` high, `count` steps 0011→0101→1001→1000→1011→1010→0110→0100→0111 (A is bit 3, D is bit 0), one step per falling edge.
- R5: From 0111 with `en` high, the next code is 0011, so the loop repeats with a period of nine edges.
- R6: The excitation maps each unused code (0000, 0001, 0010, 1100, 1101, 1110, 1111) with `en` high to J/K values that load 0011 in one edge.
- R7: `count` changes only on the falling clock edge; a rising edge never alters it.
- R8: Each storage cell obeys J=0,K=0 hold; J=1,K=0 set; J=0,K=1 clear; J=1,K=1 invert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset to 0011 |
| en | input | 1 | Advance enable; low holds the state |
| count | output | 4 | Present code, bit 3 = A, bit 0 = D |

## Verification
The counter runs through more than two full loops with enable held high. This separates a wrong successor from a wrong wrap back to the start. Enable is then dropped for several edges to show that holding is distinct from stepping. Reset is raised with enable high from each of the nine loop positions, which shows that reset wins over advance from every code. The excitation stage and a single storage cell are also driven directly. This reaches the unused codes and the invert case, which the counter alone never produces.

// File: rtl/seq9_pkg.sv
package seq9_pkg;

  localparam int CNT_W    = 4;
  localparam int N_STATES = 9;

  typedef logic [CNT_W-1:0] code_t;

  localparam code_t START_CODE = 4'b0011;
  localparam code_t LAST_CODE  = 4'b0111;

  // Successor on the loop; codes off the loop fall back to the start.
  function automatic code_t seq9_succ(input code_t c);
    code_t n;
    case (c)
      4'b0011: n = 4'b0101;
      4'b0101: n = 4'b1001;
      4'b1001: n = 4'b1000;
      4'b1000: n = 4'b1011;
      4'b1011: n = 4'b1010;
      4'b1010: n = 4'b0110;
      4'b0110: n = 4'b0100;
      4'b0100: n = 4'b0111;
      4'b0111: n = 4'b0011;
      default: n = START_CODE;
    endcase
    return n;
  endfunction

  // True when the code belongs to the nine-state loop.
  function automatic logic seq9_on_loop(input code_t c);
    logic hit;
    case (c)
      4'b0011, 4'b0101, 4'b1001, 4'b1000, 4'b1011,
      4'b1010, 4'b0110, 4'b0100, 4'b0111: hit = 1'b1;
      default:                            hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Code the cells should hold after the next falling edge.
  function automatic code_t seq9_target(input code_t c, input logic rst,
                                        input logic en);
    code_t t;
    if (rst)      t = START_CODE;
    else if (en)  t = seq9_succ(c);
    else          t = c;
    return t;
  endfunction

endpackage

// File: rtl/seq9_jk_cell.sv
module seq9_jk_cell (
  input  logic clk,
  input  logic j,
  input  logic k,
  output logic q
);

  always_ff @(negedge clk) begin
    case ({j, k})
      2'b10:   q <= 1'b1;
      2'b01:   q <= 1'b0;
      2'b11:   q <= ~q;
      default: q <= q;
    endcase
  end

endmodule

// File: rtl/seq9_excite.sv
module seq9_excite
  import seq9_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic [W-1:0] q,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] j,
  output logic [W-1:0] k,
  output logic         code_bad,
  output logic         wrap_evt
);

  code_t tgt;

  always_comb begin
    tgt = seq9_target(code_t'(q), rst, en);
  end

  // Free terms resolved so a cell is only set or cleared, never inverted.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign j[b] = ~q[b] &  tgt[b];
    assign k[b] =  q[b] & ~tgt[b];
  end

  assign code_bad = ~seq9_on_loop(code_t'(q));
  assign wrap_evt = ~rst & en & (code_t'(q) == LAST_CODE);

endmodule

// File: rtl/seq9_counter.sv
module seq9_counter
  import seq9_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] state_q;
  logic [CNT_W-1:0] j_vec;
  logic [CNT_W-1:0] k_vec;
  logic             code_bad;
  logic             wrap_evt;

  seq9_excite #(.W(CNT_W)) u_exc (
    .q        (state_q),
    .rst      (rst),
    .en       (en),
    .j        (j_vec),
    .k        (k_vec),
    .code_bad (code_bad),
    .wrap_evt (wrap_evt)
  );

  for (genvar b = 0; b < CNT_W; b++) begin : g_cell
    seq9_jk_cell u_jk (
      .clk (clk),
      .j   (j_vec[b]),
      .k   (k_vec[b]),
      .q   (state_q[b])
    );
  end

  assign count = state_q;

endmodule

// File: rtl/seq9_counter_chk.sv
module seq9_counter_chk
  import seq9_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] j_vec,
  input logic [CNT_W-1:0] k_vec,
  input logic             code_bad,
  input logic             wrap_evt
);

  logic primed   = 1'b0;
  logic seen_rst = 1'b0;

  always_ff @(negedge clk) begin
    primed <= 1'b1;
    if (rst) seen_rst <= 1'b1;
  end

  // R1
  rst_load_chk: assert property (@(negedge clk) disable iff (!primed)
    rst |=> count == START_CODE);

  // R2
  rst_over_en_chk: assert property (@(negedge clk) disable iff (!primed)
    (rst && en) |=> count == START_CODE);

  // R3
  hold_chk: assert property (@(negedge clk) disable iff (!primed)
    (!rst && !en) |=> $stable(count));

  // R5
  wrap_chk: assert property (@(negedge clk) disable iff (!primed)
    wrap_evt |=> count == START_CODE);

  // R4
  on_loop_chk: assert property (@(negedge clk) disable iff (!seen_rst)
    !code_bad);

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    // R8
    set_chk: assert property (@(negedge clk) disable iff (!primed)
      (j_vec[b] && !k_vec[b]) |=> count[b]);
    // R8
    clr_chk: assert property (@(negedge clk) disable iff (!primed)
      (!j_vec[b] && k_vec[b]) |=> !count[b]);
    // R8
    keep_chk: assert property (@(negedge clk) disable iff (!primed)
      (!j_vec[b] && !k_vec[b]) |=> $stable(count[b]));
  end

endmodule

bind seq9_counter seq9_counter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .count    (count),
  .j_vec    (j_vec),
  .k_vec    (k_vec),
  .code_bad (code_bad),
  .wrap_evt (wrap_evt)
);

// File: tb/seq9_counter_tb.sv
module seq9_counter_tb;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       en_i = 1'b0;
  logic [3:0] count;

  logic [3:0] ex_q = 4'b0000;
  logic       ex_rst = 1'b0;
  logic       ex_en = 1'b1;
  logic [3:0] ex_j, ex_k;
  logic       ex_bad, ex_wrap;

  logic cj = 1'b0, ck = 1'b0, cq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [3:0] model = 4'b0000;
  int order[$] = '{3, 5, 9, 8, 11, 10, 6, 4, 7};
  int unused[$] = '{0, 1, 2, 12, 13, 14, 15};

  always #(PERIOD/2) clk = ~clk;

  seq9_counter u_dut (.clk(clk), .rst(rst_i), .en(en_i), .count(count));

  seq9_excite #(.W(4)) u_exc_probe (
    .q(ex_q), .rst(ex_rst), .en(ex_en), .j(ex_j), .k(ex_k),
    .code_bad(ex_bad), .wrap_evt(ex_wrap)
  );

  seq9_jk_cell u_cell_probe (.clk(clk), .j(cj), .k(ck), .q(cq));

  function automatic logic [3:0] ref_next(logic [3:0] s, logic r, logic e);
    if (r) return 4'd3;
    if (!e) return s;
    foreach (order[i]) if (order[i] == int'(s)) return 4'(order[(i + 1) % order.size()]);
    return 4'd3;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One falling edge on the counter, then a look after the next rising edge.
  task automatic tick(input logic r, input logic e, input string req);
    rst_i = r;
    en_i  = e;
    @(negedge clk);
    #2;
    model = ref_next(model, r, e);
    chk(req, count, model);
    @(posedge clk);
    #1;
    chk("R7", count, model);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    tick(1'b1, 1'b0, "R1");
    // R4 / R5: more than two full loops
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, (model == 4'd7) ? "R5" : "R4");
    // R3: hold with enable low
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, "R3");
    // R1 / R2: reset with enable high from each loop position
    for (int p = 0; p < 9; p++) begin
      tick(1'b1, 1'b0, "R1");
      for (int s = 0; s < p; s++) tick(1'b0, 1'b1, "R4");
      tick(1'b1, 1'b1, "R2");
    end
    // R6: unused codes through the excitation stage, J-K rule applied here
    foreach (unused[i]) begin
      ex_q = 4'(unused[i]); ex_rst = 1'b0; ex_en = 1'b1;
      #1;
      chk("R6", (ex_j & ~ex_q) | (~ex_k & ex_q), 4'd3);
    end
    // R4: loop codes through the excitation stage
    foreach (order[i]) begin
      ex_q = 4'(order[i]);
      #1;
      chk("R4", (ex_j & ~ex_q) | (~ex_k & ex_q), ref_next(ex_q, 1'b0, 1'b1));
    end
    // R8: single cell, all four J/K combinations
    @(posedge clk); #1; cj = 1'b0; ck = 1'b1;
    @(negedge clk); #2; chk("R8 clear", {3'b0, cq}, 4'd0);
    cj = 1'b1; ck = 1'b0;
    @(negedge clk); #2; chk("R8 set", {3'b0, cq}, 4'd1);
    cj = 1'b0; ck = 1'b0;
    @(negedge clk); #2; chk("R8 hold", {3'b0, cq}, 4'd1);
    cj = 1'b1; ck = 1'b1;
    @(negedge clk); #2; chk("R8 invert", {3'b0, cq}, 4'd0);
    @(negedge clk); #2; chk("R8 invert", {3'b0, cq}, 4'd1);
    finish_run();
  end

endmodule